// File: doc/BRIEF.md
# SPI Flash Probe and Unprotect Sequencer

This block runs once after power-up, or whenever software pulses its start input, to find out what serial flash is attached and how large it is. It drives a byte-level SPI transaction engine through a request/acknowledge handshake. It offers one byte at a time, together with a flag that tells the engine to release chip select after that byte. The engine returns one acknowledge per byte, with the byte it shifted in.

The probe first reads the status register until the device reports idle. It then issues the identification read and collects three bytes. These are checked against a short list of accepted vendor and memory-type codes, and the capacity code is turned into a count of 4 KB erase sectors. When the device is recognised, the block clears every protection bit: it sends a write enable and then writes zero to the status register. An unrecognised device ends the probe at once, with an error indication.

Top module: `flash_probe`

## Requirements
- R1: After reset, done_o, ok_o and sectors_o are all zero and xfer_req_o is low.
- R2: A probe begins with a status read: byte 0x05 (last=0), then dummy byte 0x00 (last=1). If bit 0 of the returned status is 1, the same pair is sent again, until a status with bit 0 clear is returned.
- R3: The identification read sends byte 0x9F (last=0) and then three dummy bytes 0x00, with last=1 on the third only. The bytes returned with the three dummies are taken as vendor, memory type and capacity, in that order.
- R4: A device is accepted only when the vendor byte is 0xEF or 0x37 and the memory type is 0x30, 0x40, 0x50 or 0x60. Otherwise the probe ends with done_o=1, ok_o=0 and sectors_o=0.
- R5: Capacity codes 0x14, 0x15, 0x16, 0x17 and 0x18 give sectors_o of 256, 512, 1024, 2048 and 4096. Any other code fails as in R4.
- R6: After an accepted device the block sends 0x06 (last=1), then 0x01, 0x00, 0x00 with last=1 on the final byte. Only then does it raise done_o with ok_o=1.
- R7: A failed probe sends no byte after the identification read.
- R8: done_o, ok_o and sectors_o hold their values until the next start_i pulse. A start_i pulse clears done_o on the following cycle and restarts the probe from R2.
- R9: While xfer_req_o is high and no acknowledge has arrived, xfer_req_o, xfer_tx_o and xfer_last_o stay stable. Exactly one byte is consumed per xfer_ack_i pulse, and xfer_req_o is low while done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that starts or restarts a probe |
| xfer_req_o | output | 1 | A byte is offered to the SPI engine |
| xfer_tx_o | output | 8 | Byte to shift out |
| xfer_last_o | output | 1 | Release chip select after this byte |
| xfer_ack_i | input | 1 | One-cycle pulse: the offered byte has been exchanged |
| xfer_rx_i | input | 8 | Byte shifted in, valid with xfer_ack_i |
| done_o | output | 1 | Probe finished |
| ok_o | output | 1 | Device recognised and unprotected |
| sectors_o | output | 13 | Number of 4 KB erase sectors, zero on failure |

## Verification
The assertions assume that the engine raises xfer_ack_i only while xfer_req_o is high, as a single-cycle pulse, and never on two cycles in a row. They also assume that start_i arrives only while no byte is outstanding. The bench engine model waits two cycles after it sees a request before it acknowledges, and then lowers the acknowledge on the next cycle. Start pulses are issued only in the idle or done state. The bench feeds status bytes with the busy bit set to exercise the repeat poll, and it records every exchanged byte so that the full command order can be compared.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;
  localparam logic [7:0] OP_STATUS_RD = 8'h05;
  localparam logic [7:0] OP_ID_RD     = 8'h9F;
  localparam logic [7:0] OP_WR_EN     = 8'h06;
  localparam logic [7:0] OP_STATUS_WR = 8'h01;
  localparam logic [7:0] BYTE_FILL    = 8'h00;

  typedef enum logic [3:0] {
    S_IDLE, S_POLL_CMD, S_POLL_RD, S_ID_CMD, S_ID_B0, S_ID_B1, S_ID_B2,
    S_CHECK, S_WREN, S_WRSR_CMD, S_WRSR_D0, S_WRSR_D1, S_DONE
  } probe_state_e;
endpackage

// File: rtl/flash_id_capture.sv
module flash_id_capture #(
  parameter int NUM_BYTES = 3,
  localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      wr_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [7:0]                data_i,
  output logic [NUM_BYTES-1:0][7:0] bytes_o
);
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   bytes_o[g] <= '0;
      else if (clr_i)                                bytes_o[g] <= '0;
      else if (wr_i && idx_i == IDX_W'(g))           bytes_o[g] <= data_i;
    end
  end
endmodule

// File: rtl/flash_id_decode.sv
module flash_id_decode #(
  parameter int         SECT_W    = 13,
  parameter logic [7:0] CAP_BASE  = 8'h14,
  parameter int         CAP_COUNT = 5,
  parameter int         MIN_SECT  = 256
) (
  input  logic [7:0]        vendor_i,
  input  logic [7:0]        mtype_i,
  input  logic [7:0]        cap_i,
  output logic              valid_o,
  output logic [SECT_W-1:0] sectors_o
);
  logic vendor_ok, mtype_ok, cap_ok;
  logic [SECT_W-1:0] cap_sect;

  always_comb begin
    vendor_ok = (vendor_i == 8'hEF) || (vendor_i == 8'h37);
    mtype_ok  = (mtype_i == 8'h30) || (mtype_i == 8'h40) ||
                (mtype_i == 8'h50) || (mtype_i == 8'h60);
    cap_ok    = 1'b0;
    cap_sect  = '0;
    for (int i = 0; i < CAP_COUNT; i++) begin
      if (cap_i == CAP_BASE + 8'(i)) begin
        cap_ok   = 1'b1;
        cap_sect = SECT_W'(MIN_SECT) << i;
      end
    end
    valid_o   = vendor_ok && mtype_ok && cap_ok;
    sectors_o = valid_o ? cap_sect : '0;
  end

  always_comb begin
    if (!valid_o) assert_fail_zero_R4: assert (sectors_o == '0);
    if (valid_o)  assert_onehot_size_R5: assert ($onehot(sectors_o));
  end
endmodule

// File: rtl/flash_probe.sv
module flash_probe
  import flash_probe_pkg::*;
#(
  parameter int SECT_W = 13,
  localparam int ID_BYTES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              xfer_req_o,
  output logic [7:0]        xfer_tx_o,
  output logic              xfer_last_o,
  input  logic              xfer_ack_i,
  input  logic [7:0]        xfer_rx_i,
  output logic              done_o,
  output logic              ok_o,
  output logic [SECT_W-1:0] sectors_o
);
  probe_state_e state_q, state_d;
  logic                       ok_q;
  logic [SECT_W-1:0]          sect_q;
  logic [ID_BYTES-1:0][7:0]   id_bytes;
  logic                       id_wr;
  logic [1:0]                 id_idx;
  logic                       dec_valid;
  logic [SECT_W-1:0]          dec_sect;

  always_comb begin
    id_wr  = 1'b0;
    id_idx = 2'd0;
    unique case (state_q)
      S_ID_B0: begin id_wr = xfer_ack_i; id_idx = 2'd0; end
      S_ID_B1: begin id_wr = xfer_ack_i; id_idx = 2'd1; end
      S_ID_B2: begin id_wr = xfer_ack_i; id_idx = 2'd2; end
      default: ;
    endcase
  end

  flash_id_capture #(.NUM_BYTES(ID_BYTES)) u_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .wr_i   (id_wr),
    .idx_i  (id_idx),
    .data_i (xfer_rx_i),
    .bytes_o(id_bytes)
  );

  flash_id_decode #(.SECT_W(SECT_W)) u_decode (
    .vendor_i (id_bytes[0]),
    .mtype_i  (id_bytes[1]),
    .cap_i    (id_bytes[2]),
    .valid_o  (dec_valid),
    .sectors_o(dec_sect)
  );

  // byte offered in each transfer state
  always_comb begin
    xfer_req_o  = 1'b1;
    xfer_tx_o   = BYTE_FILL;
    xfer_last_o = 1'b0;
    unique case (state_q)
      S_POLL_CMD: xfer_tx_o = OP_STATUS_RD;
      S_POLL_RD:  xfer_last_o = 1'b1;
      S_ID_CMD:   xfer_tx_o = OP_ID_RD;
      S_ID_B0, S_ID_B1, S_WRSR_D0: ;
      S_ID_B2, S_WRSR_D1: xfer_last_o = 1'b1;
      S_WREN:     begin xfer_tx_o = OP_WR_EN; xfer_last_o = 1'b1; end
      S_WRSR_CMD: xfer_tx_o = OP_STATUS_WR;
      default:    xfer_req_o = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    if (start_i) begin
      state_d = S_POLL_CMD;
    end else begin
      unique case (state_q)
        S_CHECK: state_d = dec_valid ? S_WREN : S_DONE;
        S_IDLE, S_DONE: ;
        default: if (xfer_ack_i) begin
          unique case (state_q)
            S_POLL_CMD: state_d = S_POLL_RD;
            S_POLL_RD:  state_d = xfer_rx_i[0] ? S_POLL_CMD : S_ID_CMD;
            S_ID_CMD:   state_d = S_ID_B0;
            S_ID_B0:    state_d = S_ID_B1;
            S_ID_B1:    state_d = S_ID_B2;
            S_ID_B2:    state_d = S_CHECK;
            S_WREN:     state_d = S_WRSR_CMD;
            S_WRSR_CMD: state_d = S_WRSR_D0;
            S_WRSR_D0:  state_d = S_WRSR_D1;
            default:    state_d = S_DONE;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ok_q    <= 1'b0;
      sect_q  <= '0;
    end else begin
      state_q <= state_d;
      if (start_i) begin
        ok_q   <= 1'b0;
        sect_q <= '0;
      end else if (state_q == S_CHECK) begin
        ok_q   <= dec_valid;
        sect_q <= dec_sect;
      end
    end
  end

  assign done_o    = (state_q == S_DONE);
  assign ok_o      = done_o && ok_q;
  assign sectors_o = done_o ? sect_q : '0;

  assert_req_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && !xfer_ack_i && !start_i) |=>
      (xfer_req_o && $stable(xfer_tx_o) && $stable(xfer_last_o)));
  assert_no_req_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !xfer_req_o);
  assert_done_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(ok_o) && $stable(sectors_o)));
  assert_start_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);
  assert_busy_repoll_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_POLL_RD && xfer_ack_i && xfer_rx_i[0] && !start_i) |=>
      (state_q == S_POLL_CMD));
  assert_fail_skip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && !ok_o) |-> ($past(state_q) == S_CHECK));
  assert_ok_after_unprotect_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && ok_o) |-> ($past(state_q) == S_WRSR_D1));
  assert_ok_size_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> $onehot(sectors_o));
endmodule

// File: tb/flash_probe_tb.sv
module flash_probe_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  localparam int LOG_N = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        xfer_req_o;
  logic [7:0]  xfer_tx_o;
  logic        xfer_last_o;
  logic        xfer_ack_i = 1'b0;
  logic [7:0]  xfer_rx_i = 8'h00;
  logic        done_o;
  logic        ok_o;
  logic [12:0] sectors_o;

  int checks = 0;
  int errors = 0;
  int stab_err = 0;

  // {busy polls[3:0], vendor, mtype, cap, ok, sectors[12:0]}
  localparam logic [41:0] VECS [NV] = '{
    {4'd0, 8'hEF, 8'h40, 8'h17, 1'b1, 13'd2048},
    {4'd2, 8'h37, 8'h30, 8'h14, 1'b1, 13'd256},
    {4'd1, 8'hEF, 8'h60, 8'h18, 1'b1, 13'd4096},
    {4'd0, 8'h37, 8'h50, 8'h15, 1'b1, 13'd512},
    {4'd3, 8'hEF, 8'h30, 8'h16, 1'b1, 13'd1024},
    {4'd0, 8'hC2, 8'h40, 8'h17, 1'b0, 13'd0},
    {4'd1, 8'hEF, 8'h20, 8'h17, 1'b0, 13'd0},
    {4'd0, 8'hEF, 8'h40, 8'h13, 1'b0, 13'd0},
    {4'd0, 8'hEF, 8'h40, 8'h19, 1'b0, 13'd0},
    {4'd2, 8'h37, 8'h60, 8'hFF, 1'b0, 13'd0}
  };

  flash_probe dut_i (
    .clk_i, .rst_ni, .start_i, .xfer_req_o, .xfer_tx_o, .xfer_last_o,
    .xfer_ack_i, .xfer_rx_i, .done_o, .ok_o, .sectors_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // engine model state
  logic [7:0] log_tx [LOG_N];
  logic       log_last [LOG_N];
  int         log_n = 0;
  int         polls_left = 0;
  int         id_pos = 0;
  logic [7:0] id_resp [3];
  logic [7:0] prev_tx = 8'h00;

  initial begin
    forever begin
      @(negedge clk_i);
      xfer_ack_i = 1'b0;
      if (rst_ni && xfer_req_o) begin
        automatic logic [7:0] tx = xfer_tx_o;
        automatic logic       ls = xfer_last_o;
        repeat (2) begin
          @(negedge clk_i);
          if (!xfer_req_o || xfer_tx_o != tx || xfer_last_o != ls) stab_err++;
        end
        if (log_n < LOG_N) begin
          log_tx[log_n] = tx;
          log_last[log_n] = ls;
        end
        log_n++;
        xfer_rx_i = 8'h00;
        if (id_pos > 0) begin
          xfer_rx_i = id_resp[id_pos-1];
          id_pos = (id_pos == 3) ? 0 : id_pos + 1;
        end else if (prev_tx == 8'h05 && tx == 8'h00) begin
          if (polls_left > 0) begin
            xfer_rx_i = 8'h03;
            polls_left--;
          end else begin
            xfer_rx_i = 8'h02;
          end
        end
        if (tx == 8'h9F) id_pos = 1;
        prev_tx = tx;
        xfer_ack_i = 1'b1;
      end
    end
  end

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output bit hit);
    hit = 1'b0;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk_i);
      if (done_o) begin hit = 1'b1; break; end
    end
  endtask

  task automatic run_vec(input logic [41:0] v);
    automatic int    polls = int'(v[41:38]);
    automatic logic  eok = v[13];
    automatic int    esec = int'(v[12:0]);
    automatic logic [7:0] etx [LOG_N];
    automatic logic       els [LOG_N];
    automatic int    en = 0;
    automatic bit    hit;
    automatic bit    seq_ok = 1'b1;
    id_resp[0] = v[37:30];
    id_resp[1] = v[29:22];
    id_resp[2] = v[21:14];
    polls_left = polls;
    id_pos = 0;
    prev_tx = 8'h00;
    log_n = 0;
    for (int p = 0; p <= polls; p++) begin
      etx[en] = 8'h05; els[en] = 1'b0; en++;
      etx[en] = 8'h00; els[en] = 1'b1; en++;
    end
    etx[en] = 8'h9F; els[en] = 1'b0; en++;
    etx[en] = 8'h00; els[en] = 1'b0; en++;
    etx[en] = 8'h00; els[en] = 1'b0; en++;
    etx[en] = 8'h00; els[en] = 1'b1; en++;
    if (eok) begin
      etx[en] = 8'h06; els[en] = 1'b1; en++;
      etx[en] = 8'h01; els[en] = 1'b0; en++;
      etx[en] = 8'h00; els[en] = 1'b0; en++;
      etx[en] = 8'h00; els[en] = 1'b1; en++;
    end
    pulse_start();
    wait_done(hit);
    check(hit, "R8", "done reached", int'(hit), 1);
    repeat (4) @(negedge clk_i);
    check(ok_o == eok, eok ? "R6" : "R4", "ok", int'(ok_o), int'(eok));
    check(int'(sectors_o) == esec, "R5", "sectors", int'(sectors_o), esec);
    // R7: failed probe has no unprotect bytes; R2/R3/R6 byte order
    check(log_n == en, eok ? "R6" : "R7", "byte count", log_n, en);
    for (int i = 0; i < en && i < log_n; i++)
      if (log_tx[i] != etx[i] || log_last[i] != els[i]) seq_ok = 1'b0;
    check(seq_ok, "R2 R3", "byte order", int'(seq_ok), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    automatic bit hit;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check(!done_o && !ok_o && sectors_o == 0, "R1", "reset outputs",
          int'({done_o, ok_o}), 0);
    check(!xfer_req_o, "R1", "reset req", int'(xfer_req_o), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    check(!xfer_req_o && !done_o, "R1", "idle without start", int'(xfer_req_o), 0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R8: hold after done with no start
    run_vec(VECS[2]);
    repeat (30) @(negedge clk_i);
    check(done_o && ok_o && sectors_o == 13'd4096, "R8", "hold sectors",
          int'(sectors_o), 4096);
    check(!xfer_req_o, "R9", "no req while done", int'(xfer_req_o), 0);

    // R8: start clears done on the next cycle
    id_resp[0] = 8'hEF; id_resp[1] = 8'h40; id_resp[2] = 8'h14;
    polls_left = 0; id_pos = 0; prev_tx = 8'h00; log_n = 0;
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(!done_o && !ok_o && sectors_o == 0, "R8", "start clears done",
          int'(done_o), 0);
    wait_done(hit);
    repeat (2) @(negedge clk_i);
    check(hit && ok_o && sectors_o == 13'd256, "R8", "restart result",
          int'(sectors_o), 256);

    check(stab_err == 0, "R9", "request stable until ack", stab_err, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule